// File: doc/BRIEF.md
# CAN Receive-Side Interrupt Flag Register

This block holds the eight interrupt status flags of a CAN controller together with an interrupt enable register of the same width. The controller core drives one condition input per flag. A flag latches to 1 in the cycle after its condition is seen and stays at 1 after the condition goes away. Software clears a flag by writing 1 to its bit. Such a write only takes effect once the condition that set the flag has gone. The flags are masked by their enables and merged into three interrupt lines: wake-up, error and receive.

The receive warning flag is not driven by a plain input. The block derives it from the receive error count, which arrives on a port. The block also reports whether the controller has acknowledged sleep, and it withdraws that acknowledge when bus activity wakes the controller. The register pair is reached through a simple synchronous bus. A write is captured on the clock edge, and the read data is a combinational function of the address.

Top module: `canirq_flag_reg`

## Requirements
- R1: A condition input that is high at a clock edge makes its flag read 1 after that edge. The flag then stays at 1 once the condition falls, until it is cleared by software or reset.
- R2: A write to the flag address clears each flag whose write-data bit is 1, provided its cause is absent. Bits written 0 are left unchanged. The flag positions, from bit 7 down to bit 0, are: wake-up, receive warning, transmit warning, receive error-passive, transmit error-passive, bus-off, overrun, receive-frame-ready.
- R3: A clear request for a flag whose condition is high in the same cycle leaves that flag at 1.
- R4: The enable register is at address 1 and the flags are at address 0. Reads have no side effects. Any other address reads 0.
- R5: Both the asynchronous hard reset (rst_n low) and the synchronous soft reset (soft_rst high) force all flags and all enables to 0.
- R6: When bus activity is seen while sleep_mode is high, the wake-up flag (bit 7) is set and sleep_ack falls in the same cycle. sleep_ack rises one cycle after sleep_mode is raised, and it stays low after a wake-up until sleep_mode has been dropped.
- R7: The receive warning flag (bit 6) is set when rx_err_cnt is strictly greater than 96, but only while none of the receive error-passive, transmit error-passive or bus-off flags is set. A count of exactly 96 does not set it.
- R8: The outputs are built from flags masked by their enables. irq_wake comes from bit 7 and irq_rx from bit 0. irq_err is the OR of bits 6 to 2, plus bit 1 when OVR_TO_ERR is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| sleep_mode | input | 1 | Controller is in sleep mode |
| bus_active | input | 1 | Activity detected on the CAN bus |
| tx_warn_cond | input | 1 | Transmit warning state |
| rx_passive_cond | input | 1 | Receive error-passive state |
| tx_passive_cond | input | 1 | Transmit error-passive state |
| busoff_cond | input | 1 | Bus-off state |
| overrun_cond | input | 1 | Receive overrun event |
| rx_ready_cond | input | 1 | Received frame ready |
| rx_err_cnt | input | CNT_W | Receive error count |
| sleep_ack | output | 1 | Sleep acknowledge status |
| irq_wake | output | 1 | Wake-up interrupt |
| irq_err | output | 1 | Error interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit error count, a warning threshold of 96, and overrun routed into the error interrupt. With the threshold at 96, the bench can drive both sides of the boundary, at 96 and 97. With overrun routed into the error line, the overrun path can be observed on irq_err. Because the address width is 2, a spare address is also available, which lets the bench read a location that maps to neither register.

// File: rtl/canirq_pkg.sv
package canirq_pkg;
   localparam int NUM_FLAGS = 8;
   localparam int B_WAKE    = 7;
   localparam int B_RWARN   = 6;
   localparam int B_TWARN   = 5;
   localparam int B_RPASS   = 4;
   localparam int B_TPASS   = 3;
   localparam int B_BOFF    = 2;
   localparam int B_OVR     = 1;
   localparam int B_RXRDY   = 0;
   typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/canirq_flag_bit.sv
module canirq_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic cond,
   input  logic clr_req,
   output logic q
);
   logic clr_ok;
   assign clr_ok = clr_req & ~cond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (soft_rst) q <= 1'b0;
      else               q <= cond | (q & ~clr_ok);
   end

   AST_SET_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cond && !soft_rst) |=> q);                                  // R1
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr_req && !soft_rst) |=> q);                         // R2
   AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (q && clr_req && cond && !soft_rst) |=> q);                  // R3
endmodule

// File: rtl/canirq_combine.sv
module canirq_combine
   import canirq_pkg::*;
#(
   parameter bit OVR_TO_ERR = 1'b1
) (
   input  flag_vec_t flags,
   input  flag_vec_t enables,
   output logic      irq_wake,
   output logic      irq_err,
   output logic      irq_rx
);
   flag_vec_t live;
   logic      err_core;
   logic      ovr_part;

   assign live     = flags & enables;
   assign irq_wake = live[B_WAKE];
   assign irq_rx   = live[B_RXRDY];
   assign err_core = |live[B_RWARN:B_BOFF];

   generate
      if (OVR_TO_ERR) begin : g_ovr_err
         assign ovr_part = live[B_OVR];
      end else begin : g_ovr_none
         assign ovr_part = 1'b0;
      end
   endgenerate

   assign irq_err = err_core | ovr_part;

   always_comb begin
      AST_RX_SOURCE: assert (!(irq_rx && !flags[B_RXRDY]));        // R8
   end
endmodule

// File: rtl/canirq_flag_reg.sv
module canirq_flag_reg
   import canirq_pkg::*;
#(
   parameter int ADDR_W     = 2,
   parameter int FLAG_ADDR  = 0,
   parameter int EN_ADDR    = 1,
   parameter int CNT_W      = 8,
   parameter int WARN_LIMIT = 96,
   parameter bit OVR_TO_ERR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              sleep_mode,
   input  logic              bus_active,
   input  logic              tx_warn_cond,
   input  logic              rx_passive_cond,
   input  logic              tx_passive_cond,
   input  logic              busoff_cond,
   input  logic              overrun_cond,
   input  logic              rx_ready_cond,
   input  logic [CNT_W-1:0]  rx_err_cnt,
   output logic              sleep_ack,
   output logic              irq_wake,
   output logic              irq_err,
   output logic              irq_rx
);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);
   localparam logic [CNT_W-1:0]  LIMIT  = CNT_W'(WARN_LIMIT);

   initial begin
      AST_PARAM_ADDR: assert (FLAG_ADDR != EN_ADDR && FLAG_ADDR < (1 << ADDR_W)
                              && EN_ADDR < (1 << ADDR_W));         // R4
      AST_PARAM_LIMIT: assert (WARN_LIMIT < (1 << CNT_W));          // R7
   end

   flag_vec_t flags, enables, cond, clr_req;
   logic      wake_ev, rwarn_ev, woke_latch;

   assign wake_ev  = sleep_mode & bus_active;
   assign rwarn_ev = (rx_err_cnt > LIMIT) & ~flags[B_RPASS] & ~flags[B_TPASS]
                     & ~flags[B_BOFF];

   always_comb begin
      cond          = '0;
      cond[B_WAKE]  = wake_ev;
      cond[B_RWARN] = rwarn_ev;
      cond[B_TWARN] = tx_warn_cond;
      cond[B_RPASS] = rx_passive_cond;
      cond[B_TPASS] = tx_passive_cond;
      cond[B_BOFF]  = busoff_cond;
      cond[B_OVR]   = overrun_cond;
      cond[B_RXRDY] = rx_ready_cond;
   end

   assign clr_req = (bus_we && bus_addr == A_FLAG) ? bus_wdata : '0;

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         canirq_flag_bit u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .soft_rst(soft_rst),
            .cond    (cond[i]),
            .clr_req (clr_req[i]),
            .q       (flags[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          enables <= '0;
      else if (soft_rst)                   enables <= '0;
      else if (bus_we && bus_addr == A_EN) enables <= bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         woke_latch <= 1'b0;
         sleep_ack  <= 1'b0;
      end else if (soft_rst || !sleep_mode) begin
         woke_latch <= 1'b0;
         sleep_ack  <= 1'b0;
      end else begin
         woke_latch <= woke_latch | wake_ev;
         sleep_ack  <= ~wake_ev & ~woke_latch;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_FLAG)    bus_rdata = flags;
      else if (bus_addr == A_EN) bus_rdata = enables;
   end

   canirq_combine #(.OVR_TO_ERR(OVR_TO_ERR)) u_comb (
      .flags   (flags),
      .enables (enables),
      .irq_wake(irq_wake),
      .irq_err (irq_err),
      .irq_rx  (irq_rx)
   );

   AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (flags == '0 && enables == '0));                // R5
   AST_WAKE_DROPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_ev && !soft_rst) |=> (!sleep_ack && flags[B_WAKE]));   // R6
   AST_RWARN_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[B_RWARN] && (flags[B_RPASS] || flags[B_TPASS] || flags[B_BOFF]))
      |=> !flags[B_RWARN]);                                         // R7
   AST_ERR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |-> (|flags[B_RWARN:B_OVR]));                         // R8
endmodule

// File: tb/sim_canirq_flag_reg.sv
`timescale 1ns/1ps
module sim_canirq_flag_reg;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, soft_rst, bus_we;
   logic [1:0] bus_addr;
   logic [7:0] bus_wdata, bus_rdata, rx_err_cnt;
   logic sleep_mode, bus_active, tx_warn_cond, rx_passive_cond, tx_passive_cond;
   logic busoff_cond, overrun_cond, rx_ready_cond;
   logic sleep_ack, irq_wake, irq_err, irq_rx;

   canirq_flag_reg u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sleep_mode(sleep_mode), .bus_active(bus_active),
      .tx_warn_cond(tx_warn_cond), .rx_passive_cond(rx_passive_cond),
      .tx_passive_cond(tx_passive_cond), .busoff_cond(busoff_cond),
      .overrun_cond(overrun_cond), .rx_ready_cond(rx_ready_cond),
      .rx_err_cnt(rx_err_cnt), .sleep_ack(sleep_ack), .irq_wake(irq_wake),
      .irq_err(irq_err), .irq_rx(irq_rx)
   );

   typedef struct {
      logic [7:0] rd;
      logic [2:0] irq;
      logic       ack;
      string      tag;
   } exp_t;

   exp_t sb[$];
   int   n_run = 0, n_fail = 0;
   bit   done = 0;

   localparam logic [1:0] A_FLAG = 2'd0, A_EN = 2'd1, A_SPARE = 2'd3;

   // monitor: pops expected items and compares against the ports
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_run++;
         if (bus_rdata !== e.rd || {irq_wake, irq_err, irq_rx} !== e.irq ||
             sleep_ack !== e.ack) begin
            n_fail++;
            $display("FAIL %s: rd=%h exp %h irq=%b exp %b ack=%b exp %b",
                     e.tag, bus_rdata, e.rd, {irq_wake, irq_err, irq_rx},
                     e.irq, sleep_ack, e.ack);
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   // driver: pushes one expected item and waits for the monitor
   task automatic chk(input logic [1:0] a, input logic [7:0] rd,
                      input logic [2:0] irq, input logic ack, input string tag);
      exp_t e;
      bus_addr = a;
      e.rd = rd; e.irq = irq; e.ack = ack; e.tag = tag;
      sb.push_back(e);
      wait (sb.size() == 0);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      tick();
      bus_we = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run=%0d exp finished", n_run);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; soft_rst = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
      sleep_mode = 0; bus_active = 0; tx_warn_cond = 0; rx_passive_cond = 0;
      tx_passive_cond = 0; busoff_cond = 0; overrun_cond = 0; rx_ready_cond = 0;
      rx_err_cnt = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      chk(A_FLAG, 8'h00, 3'b000, 0, "R5 hard reset flags");
      chk(A_EN,   8'h00, 3'b000, 0, "R5 hard reset enables");

      wr(A_EN, 8'hFF);
      chk(A_EN, 8'hFF, 3'b000, 0, "R4 enable readback");
      chk(A_SPARE, 8'h00, 3'b000, 0, "R4 spare address");

      // R1 pulse sets sticky flag
      rx_ready_cond = 1; tick(); rx_ready_cond = 0;
      chk(A_FLAG, 8'h01, 3'b001, 0, "R1 rx ready set");
      tick(); tick();
      chk(A_FLAG, 8'h01, 3'b001, 0, "R1 sticky after cause gone");
      chk(A_FLAG, 8'h01, 3'b001, 0, "R4 read has no side effect");

      // R2 write 0 no effect, write 1 clears
      wr(A_FLAG, 8'hFE);
      chk(A_FLAG, 8'h01, 3'b001, 0, "R2 write zero ignored");
      wr(A_FLAG, 8'h01);
      chk(A_FLAG, 8'h00, 3'b000, 0, "R2 write one clears");

      // R3 clear blocked while cause active
      overrun_cond = 1; tick();
      wr(A_FLAG, 8'h02);
      chk(A_FLAG, 8'h02, 3'b010, 0, "R3 clear blocked, R8 overrun to err");
      overrun_cond = 0;
      wr(A_FLAG, 8'h02);
      chk(A_FLAG, 8'h00, 3'b000, 0, "R2 clear after cause gone");

      // R6 wake-up
      sleep_mode = 1; tick(); tick();
      chk(A_FLAG, 8'h00, 3'b000, 1, "R6 sleep ack raised");
      bus_active = 1; tick(); bus_active = 0;
      chk(A_FLAG, 8'h80, 3'b100, 0, "R6 wake flag, ack low");
      tick(); tick();
      chk(A_FLAG, 8'h80, 3'b100, 0, "R6 ack stays low in sleep");
      wr(A_FLAG, 8'h80);
      chk(A_FLAG, 8'h00, 3'b000, 0, "R2 wake clear");
      sleep_mode = 0; tick();
      chk(A_FLAG, 8'h00, 3'b000, 0, "R6 ack low after sleep exit");

      // R7 receive warning
      rx_err_cnt = 8'd96; tick(); tick();
      chk(A_FLAG, 8'h00, 3'b000, 0, "R7 count 96 no warning");
      rx_err_cnt = 8'd97; tick();
      chk(A_FLAG, 8'h40, 3'b010, 0, "R7 count 97 warning");
      rx_err_cnt = 8'd0; wr(A_FLAG, 8'h40);
      chk(A_FLAG, 8'h00, 3'b000, 0, "R7 warning cleared");
      rx_passive_cond = 1; tick(); rx_passive_cond = 0;
      rx_err_cnt = 8'd120; tick(); tick();
      chk(A_FLAG, 8'h10, 3'b010, 0, "R7 warning held off by error flag");
      wr(A_FLAG, 8'h10);
      tick();
      chk(A_FLAG, 8'h40, 3'b010, 0, "R7 warning after error flag cleared");
      rx_err_cnt = 8'd0; wr(A_FLAG, 8'h40);
      chk(A_FLAG, 8'h00, 3'b000, 0, "R2 clear warning");

      // R8 masking
      wr(A_EN, 8'h00);
      tx_warn_cond = 1; tick(); tx_warn_cond = 0;
      chk(A_FLAG, 8'h20, 3'b000, 0, "R8 masked tx warning");
      wr(A_EN, 8'h20);
      chk(A_FLAG, 8'h20, 3'b010, 0, "R8 enabled tx warning");

      // R3 set wins over a clear in the same cycle
      rx_ready_cond = 1; wr(A_FLAG, 8'h01); rx_ready_cond = 0;
      chk(A_FLAG, 8'h21, 3'b010, 0, "R3 set beats clear");

      // R5 soft reset
      busoff_cond = 1; tick(); busoff_cond = 0;
      chk(A_FLAG, 8'h25, 3'b010, 0, "R1 bus-off set");
      soft_rst = 1; tick(); soft_rst = 0;
      chk(A_FLAG, 8'h00, 3'b000, 0, "R5 soft reset flags");
      chk(A_EN,   8'h00, 3'b000, 0, "R5 soft reset enables");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule